// File: doc/BRIEF.md
# HDLC Transmit Framer with Mark-Idle Preamble

This block drives the transmit side of one synchronous HDLC channel. It emits one line bit per clock on `tx_bit`, with `tx_en` marking the bits as valid. Between frames the line carries either a repeated flag (`01111110`) or continuous ones (mark). A byte source presents frame bytes on a valid/ready pair and tags the final byte with `src_last`. The framer then sends the data bytes least-significant bit first with zero-bit insertion, an optional 16-bit FCS, and one closing flag. After that it returns to the idle pattern.

In mark-idle mode each frame is preceded by a preamble, which lets the far-end clock recovery lock before the first flag. The preamble is a programmable run of pad bytes (all zeros or alternating `0xAA`), followed by a programmable run of opening flags. In flag-idle mode the idle flags already delimit the frame, so data follows the last idle flag directly. If the source runs dry in the middle of a frame, the framer aborts with a run of ones.

The sequencer states are IDLE (idle pattern), PAD (preamble pad bytes), OPEN (opening flags), DATA (stuffed data), FCS (stuffed check field), CLOSE (closing flag) and ABORT (eight ones). Every state works in units: one byte for most states, two bytes for FCS. A stuffed zero lengthens a unit by one clock. The transitions are taken only on the last bit of a unit:
- IDLE→PAD, when a frame is waiting in mark mode and the pad count is non-zero.
- IDLE→OPEN, when a frame is waiting in mark mode and the pad count is zero.
- IDLE→DATA, when a frame is waiting in flag mode.
- PAD→OPEN, after the last pad byte.
- OPEN→DATA, after the last opening flag, if a byte is waiting.
- OPEN→ABORT, after the last opening flag, if no byte is waiting.
- DATA→DATA, when the byte just sent was not the last and the next byte is waiting.
- DATA→ABORT, when the byte just sent was not the last and no byte is waiting (underrun).
- DATA→FCS, after the last byte, when the FCS is enabled.
- DATA→CLOSE, after the last byte, when the FCS is disabled.
- FCS→CLOSE, after the second FCS byte.
- CLOSE→IDLE and ABORT→IDLE, at the end of the unit.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low, `tx_en` and `src_ready` are low. From the first clock edge after reset, `tx_en` stays high and one bit appears on `tx_bit` per clock. The first bit is bit 0 of an idle byte.
- R2: With `cfg_mark_idle`=0 and no frame pending, the line repeats the flag `0x7E` in 8-clock units aligned to the first clock after reset.
- R3: With `cfg_mark_idle`=1 and no frame pending, `tx_bit` is constantly 1.
- R4: `src_valid` is sampled on the last bit of each idle unit. In flag-idle mode a pending frame goes straight to DATA, with no pads and no extra flags.
- R5: In mark-idle mode a frame starts with `cfg_pad_cnt` pad bytes (none if zero). It continues with max(`cfg_flag_cnt`,1) flags and then the data.
- R6: A pad byte is `0x00` when `cfg_pad_aa`=0 and `0xAA` when `cfg_pad_aa`=1.
- R7: All bytes go out least-significant bit first. `src_ready` is high for exactly one clock per byte taken, and `src_data`/`src_last` are captured on that clock's edge. The byte taken with `src_last`=1 ends the frame's data.
- R8: After five consecutive 1s in data or FCS bits, a 0 is inserted. This also applies before the closing flag. Idle, pad, flag and abort bits are never stuffed.
- R9: The FCS uses the generator x^16+x^12+x^5+1 and starts from all ones. It is updated with every data bit in line order and not with stuffed, pad or flag bits. It is sent complemented, X15 first. It is omitted when `cfg_fcs_en`=0.
- R10: Exactly one closing flag follows the data (or the FCS). The selected idle pattern resumes on the next byte unit.
- R11: If a non-final byte ends and `src_valid` is low, eight 1s are sent and the framer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mark_idle | input | 1 | 1: idle in mark, 0: idle in flags |
| cfg_pad_aa | input | 1 | Pad byte select: 1 = 0xAA, 0 = 0x00 |
| cfg_pad_cnt | input | CNT_W | Number of preamble pad bytes (mark mode) |
| cfg_flag_cnt | input | CNT_W | Number of opening flags (mark mode, minimum one) |
| cfg_fcs_en | input | 1 | Append the 16-bit FCS |
| src_valid | input | 1 | A frame byte is available |
| src_data | input | 8 | Frame byte |
| src_last | input | 1 | The presented byte is the last of the frame |
| src_ready | output | 1 | The byte is taken at this clock edge |
| tx_bit | output | 1 | Serial line bit |
| tx_en | output | 1 | Bit-enable for `tx_bit` |

## Verification
`tx_bit` shows the bit chosen in a state one clock later, through one output register. The first line bit is therefore valid at the first edge after reset. A frame pending from reset starts on bit 8, after one full idle unit. `src_ready` rises combinationally in the last bit cycle of the unit before the byte is needed. The bench releases reset on a falling edge and records `tx_bit` on every falling edge while `tx_en` is high. It compares the record index by index with a stream it builds from the configuration: idle unit, preamble, stuffed data, FCS and closing flag, then two idle units. Because of this, no check depends on guessing an edge. The bench counts `src_ready` pulses on falling edges and advances its source only after the following rising edge.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAD,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
    localparam logic [7:0] PAD_ALT   = 8'hAA;

endpackage

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16 #(
    parameter int          W    = 16,
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic feed,
    input  logic data_bit,
    input  logic drain,
    output logic msb_out
);

    logic [W-1:0] acc;
    logic         fb;

    assign fb      = acc[W-1] ^ data_bit;
    assign msb_out = acc[W-1];

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            acc <= '1;
        end else if (feed) begin
            acc <= {acc[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
        end else if (drain) begin
            acc <= {acc[W-2:0], 1'b0};
        end
    end

    // R9
    fcs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(feed && drain));

endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic track,
    input  logic check,
    input  logic bit_sent,
    output logic stuff
);

    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] ones;

    assign stuff = check && (ones == CW'(RUN));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones <= '0;
        end else if (stuff || !track || !bit_sent) begin
            ones <= '0;
        end else begin
            ones <= ones + CW'(1);
        end
    end

    // R8
    stuff_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff |=> !stuff);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int BYTE_W = 8,
    parameter int FCS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mark_idle,
    input  logic             cfg_pad_aa,
    input  logic [CNT_W-1:0] cfg_pad_cnt,
    input  logic [CNT_W-1:0] cfg_flag_cnt,
    input  logic             cfg_fcs_en,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    input  logic             src_last,
    output logic             src_ready,
    output logic             tx_bit,
    output logic             tx_en
);

    localparam int BYW = $clog2(BYTE_W);
    localparam int BCW = $clog2(FCS_W);

    tx_state_e        state, state_nx;
    logic [BCW-1:0]   bcnt;
    logic [CNT_W-1:0] rep, rep_nx, open_reps;
    logic [7:0]       dbyte;
    logic             dlast;
    logic             take;
    logic             stuff;
    logic             unit_end;
    logic             cur_bit;
    logic             crc_msb;
    logic [BCW-1:0]   unit_last;
    logic [BYW-1:0]   bidx;

    assign bidx      = bcnt[BYW-1:0];
    assign unit_last = (state == ST_FCS) ? BCW'(FCS_W - 1) : BCW'(BYTE_W - 1);
    assign unit_end  = !stuff && (bcnt == unit_last);
    assign open_reps = (cfg_flag_cnt == '0) ? '0 : cfg_flag_cnt - CNT_W'(1);
    assign src_ready = take;

    hdlc_zero_stuffer #(.RUN(5)) u_stuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .track    (state == ST_DATA || state == ST_FCS),
        .check    (state == ST_DATA || state == ST_FCS ||
                   (state == ST_CLOSE && bcnt == '0)),
        .bit_sent (cur_bit),
        .stuff    (stuff)
    );

    hdlc_fcs16 #(.W(FCS_W)) u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (state != ST_DATA && state != ST_FCS),
        .feed     (state == ST_DATA && !stuff),
        .data_bit (dbyte[bidx]),
        .drain    (state == ST_FCS && !stuff),
        .msb_out  (crc_msb)
    );

    // next state, evaluated on the last bit of a unit
    always_comb begin
        state_nx = state;
        rep_nx   = rep;
        take     = 1'b0;
        if (unit_end) begin
            unique case (state)
                ST_IDLE: begin
                    if (src_valid) begin
                        if (!cfg_mark_idle) begin
                            state_nx = ST_DATA;
                            take     = 1'b1;
                        end else if (cfg_pad_cnt != '0) begin
                            state_nx = ST_PAD;
                            rep_nx   = cfg_pad_cnt - CNT_W'(1);
                        end else begin
                            state_nx = ST_OPEN;
                            rep_nx   = open_reps;
                        end
                    end
                end
                ST_PAD: begin
                    if (rep == '0) begin
                        state_nx = ST_OPEN;
                        rep_nx   = open_reps;
                    end else begin
                        rep_nx = rep - CNT_W'(1);
                    end
                end
                ST_OPEN: begin
                    if (rep != '0) begin
                        rep_nx = rep - CNT_W'(1);
                    end else if (src_valid) begin
                        state_nx = ST_DATA;
                        take     = 1'b1;
                    end else begin
                        state_nx = ST_ABORT;
                    end
                end
                ST_DATA: begin
                    if (dlast) begin
                        state_nx = cfg_fcs_en ? ST_FCS : ST_CLOSE;
                    end else if (src_valid) begin
                        take = 1'b1;
                    end else begin
                        state_nx = ST_ABORT;
                    end
                end
                ST_FCS:   state_nx = ST_CLOSE;
                ST_CLOSE: state_nx = ST_IDLE;
                ST_ABORT: state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register and unit counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rep   <= '0;
            bcnt  <= '0;
            dbyte <= '0;
            dlast <= 1'b0;
        end else begin
            state <= state_nx;
            rep   <= rep_nx;
            if (!stuff) begin
                bcnt <= unit_end ? '0 : bcnt + BCW'(1);
            end
            if (take) begin
                dbyte <= src_data;
                dlast <= src_last;
            end
        end
    end

    // line bit of the current state
    always_comb begin
        unique case (state)
            ST_IDLE:  cur_bit = cfg_mark_idle | FLAG_BYTE[bidx];
            ST_PAD:   cur_bit = cfg_pad_aa & PAD_ALT[bidx];
            ST_OPEN:  cur_bit = FLAG_BYTE[bidx];
            ST_DATA:  cur_bit = !stuff && dbyte[bidx];
            ST_FCS:   cur_bit = !stuff && !crc_msb;
            ST_CLOSE: cur_bit = !stuff && FLAG_BYTE[bidx];
            ST_ABORT: cur_bit = 1'b1;
            default:  cur_bit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= 1'b1;
            tx_en  <= 1'b0;
        end else begin
            tx_bit <= cur_bit;
            tx_en  <= 1'b1;
        end
    end

    // R1
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tx_en);

    // R3
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cfg_mark_idle) |=> tx_bit);

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD && !cfg_pad_aa) |=> !tx_bit);

    // R11
    abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABORT) |=> tx_bit);

    // R7
    ready_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |=> (state == ST_DATA && bcnt == '0));

    // R10
    close_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_CLOSE) |-> ($past(state) == ST_DATA || $past(state) == ST_FCS));

endmodule

// File: tb/test_hdlc_tx_framer.sv
module test_hdlc_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mark_idle = 1'b0, cfg_pad_aa = 1'b0, cfg_fcs_en = 1'b0;
    logic [3:0] cfg_pad_cnt = '0, cfg_flag_cnt = '0;
    logic       src_valid = 1'b0, src_last = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_ready, tx_bit, tx_en;

    always #5 clk = ~clk;

    hdlc_tx_framer i_hdlc_tx_framer (
        .clk(clk), .rst_n(rst_n), .cfg_mark_idle(cfg_mark_idle), .cfg_pad_aa(cfg_pad_aa),
        .cfg_pad_cnt(cfg_pad_cnt), .cfg_flag_cnt(cfg_flag_cnt), .cfg_fcs_en(cfg_fcs_en),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready), .tx_bit(tx_bit), .tx_en(tx_en)
    );

    int n_chk = 0, n_fail = 0;
    bit exp_q [0:1023];
    bit cap_q [0:2047];
    int n_exp, n_cap;
    bit capture_on = 1'b0;
    logic [7:0] frame [0:15];
    int idx, navail, nbytes, nready;
    logic [15:0] crc_m;
    int ones_m;

    task automatic check(input string req, input bit ok, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // line recorder
    initial forever begin
        @(negedge clk);
        if (capture_on && tx_en && n_cap < 2048) begin
            cap_q[n_cap] = tx_bit;
            n_cap++;
        end
    end

    // byte source
    initial forever begin
        @(negedge clk);
        if (rst_n && src_ready) begin
            nready++;
            @(posedge clk);
            #1;
            idx++;
            if (idx < navail && idx < nbytes) begin
                src_data = frame[idx];
                src_last = (idx == nbytes - 1);
            end else begin
                src_valid = 1'b0;
                src_last  = 1'b0;
            end
        end
    end

    task automatic push(input bit b);
        exp_q[n_exp] = b;
        n_exp++;
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int j = 0; j < 8; j++) push(b[j]);
    endtask

    task automatic data_bit(input bit b, input bit upd);
        bit fb;
        push(b);
        if (upd) begin
            fb = crc_m[15] ^ b;
            crc_m = {crc_m[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        if (b) begin
            ones_m++;
            if (ones_m == 5) begin
                push(1'b0);
                ones_m = 0;
            end
        end else begin
            ones_m = 0;
        end
    endtask

    task automatic build_exp(input bit mk, input bit aa, input int pc, input int fc,
                             input bit fe, input int nb, input int na);
        logic [15:0] snap;
        int nsent;
        n_exp = 0;
        crc_m = 16'hFFFF;
        ones_m = 0;
        push_byte(mk ? 8'hFF : 8'h7E);
        if (nb > 0) begin
            if (mk) begin
                for (int i = 0; i < pc; i++) push_byte(aa ? 8'hAA : 8'h00);
                for (int i = 0; i < ((fc == 0) ? 1 : fc); i++) push_byte(8'h7E);
            end
            nsent = (na < nb) ? na : nb;
            for (int i = 0; i < nsent; i++)
                for (int j = 0; j < 8; j++) data_bit(frame[i][j], 1'b1);
            if (na < nb) begin
                push_byte(8'hFF);
            end else begin
                if (fe) begin
                    snap = crc_m;
                    for (int k = 15; k >= 0; k--) data_bit(~snap[k], 1'b0);
                end
                push_byte(8'h7E);
            end
        end
        push_byte(mk ? 8'hFF : 8'h7E);
        push_byte(mk ? 8'hFF : 8'h7E);
    endtask

    task automatic run_case(input string req, input bit mk, input bit aa, input int pc,
                            input int fc, input bit fe, input int nb, input int na);
        int bad;
        rst_n = 1'b0;
        capture_on = 1'b0;
        @(negedge clk);
        cfg_mark_idle = mk;
        cfg_pad_aa    = aa;
        cfg_pad_cnt   = 4'(pc);
        cfg_flag_cnt  = 4'(fc);
        cfg_fcs_en    = fe;
        idx = 0; nbytes = nb; navail = na; nready = 0;
        src_valid = (nb > 0);
        src_data  = frame[0];
        src_last  = (nb == 1);
        build_exp(mk, aa, pc, fc, fe, nb, na);
        repeat (2) @(negedge clk);
        n_cap = 0;
        capture_on = 1'b1;
        rst_n = 1'b1;
        repeat (n_exp + 4) @(posedge clk);
        @(negedge clk);
        bad = -1;
        for (int i = 0; i < n_exp; i++)
            if (bad < 0 && cap_q[i] !== exp_q[i]) bad = i;
        if (bad >= 0)
            check({req, " stream bit ", $sformatf("%0d", bad)}, 1'b0, cap_q[bad], exp_q[bad]);
        else
            check(req, n_cap >= n_exp, n_cap, n_exp);
        if (nb > 0)
            check("R7 ready pulses", nready == ((na < nb) ? na : nb), nready, (na < nb) ? na : nb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 tx_en in reset", tx_en == 1'b0, tx_en, 0);
        check("R1 src_ready in reset", src_ready == 1'b0, src_ready, 0);

        // R2 and R3 idle only
        run_case("R2 flag idle", 1'b0, 1'b0, 0, 0, 1'b0, 0, 0);
        check("R1 tx_en after reset", tx_en == 1'b1, tx_en, 1);
        run_case("R3 mark idle", 1'b1, 1'b0, 0, 0, 1'b0, 0, 0);

        // sweep: R4 R5 R6 R7 R9 R10
        for (int mk = 0; mk < 2; mk++)
            for (int aa = 0; aa < 2; aa++)
                for (int p = 0; p < 3; p++)
                    for (int fc = 0; fc < 3; fc++)
                        for (int fe = 0; fe < 2; fe++)
                            for (int n = 0; n < 2; n++) begin
                                for (int i = 0; i < 4; i++)
                                    frame[i] = 8'((i * 53) + (p * 17) + (fc * 29) + 8'h3C);
                                run_case("R4 R5 R6 R7 R9 R10 frame", 1'(mk), 1'(aa),
                                         (p == 2) ? 3 : p, fc, 1'(fe),
                                         (n == 0) ? 1 : 3, (n == 0) ? 1 : 3);
                            end

        // R8 long runs of ones in data and FCS
        frame[0] = 8'hFF; frame[1] = 8'hFF; frame[2] = 8'h7E;
        run_case("R8 stuffing with fcs", 1'b1, 1'b1, 2, 1, 1'b1, 3, 3);
        run_case("R8 stuffing flag idle", 1'b0, 1'b0, 0, 0, 1'b1, 3, 3);
        frame[0] = 8'hF8;
        run_case("R8 R10 stuff before close", 1'b0, 1'b0, 0, 0, 1'b0, 1, 1);
        run_case("R8 R10 stuff before close mark", 1'b1, 1'b0, 0, 0, 1'b0, 1, 1);

        // R11 underrun
        frame[0] = 8'h12; frame[1] = 8'h34; frame[2] = 8'h56;
        run_case("R11 underrun mark", 1'b1, 1'b1, 1, 2, 1'b1, 3, 2);
        run_case("R11 underrun flag", 1'b0, 1'b0, 0, 0, 1'b1, 3, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule